// File: doc/BRIEF.md
# Run-Gated Event Timer with Sticky Overflow Request

This block is an up-counter that advances only while its run bit is set. When an active count event arrives with the counter at all ones, the counter wraps to zero. That wrap sets a sticky overflow flag, and the flag is the block's interrupt request.

The counter has two count sources. In clock mode it counts every cycle of the system clock. In event mode it counts falling transitions of an asynchronous external input, after that input has been synchronized.

Software uses a register-style write port to set the run bit, to load the count while the timer is stopped, and to force the flag to either value. The interrupt controller pulses an acknowledge input when it starts the handler, and that pulse clears the flag. Clearing the run bit freezes the count where it is, so a later start resumes from the same value.

Top module: `evt_timer`

## Requirements
- R1: After synchronous reset, `count` is 0, `running` is 0 and `irq` is 0.
- R2: When `src_sel` is 0 (clock mode) and the run bit is 1, `count` increments by one on every clock edge. A write that sets the run bit takes effect at its own edge, and the first increment happens on the following edge.
- R3: While the run bit is 0, `count` holds its value unless a load is written.
- R4: An active count event with `count` at all ones (0xFFFF at the default width of 16) gives `count` = 0 and `irq` = 1 after that same edge.
- R5: Once set, `irq` stays 1 until it is cleared by acknowledge or by a software write of 0.
- R6: A one-cycle pulse on `irq_ack` clears `irq` at that edge.
- R7: A pulse on `flag_wr` writes `flag_val` into `irq`. If an overflow occurs in the same cycle, the flag is set, whatever value was written.
- R8: When `src_sel` is 1 (event mode), `ext_evt` passes through a two-flop synchronizer, and `count` advances once for each 1-to-0 transition. The increment appears on the third clock edge after the input falls. Rising edges and steady levels do not count.
- R9: A pulse on `cnt_wr` loads `cnt_val` into `count` when the run bit is 0. The load is ignored while the timer is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_wr | input | 1 | Write strobe for the run bit |
| run_val | input | 1 | New run bit value |
| cnt_wr | input | 1 | Write strobe for the count value |
| cnt_val | input | W | Count value to load |
| flag_wr | input | 1 | Write strobe for the overflow flag |
| flag_val | input | 1 | Flag value to write |
| src_sel | input | 1 | Count source: 0 = clock, 1 = external event |
| ext_evt | input | 1 | Asynchronous external event input |
| irq_ack | input | 1 | Interrupt acknowledge; clears the flag |
| count | output | W | Current counter value |
| running | output | 1 | Current run bit |
| irq | output | 1 | Sticky overflow flag, used as the interrupt request |

## Verification
A corrupted counter or run bit shows up on `count` at the very next edge. In clock mode the count either fails to step by one or moves while the timer is stopped. An error in the wrap detection shows up at the edge where the count leaves all ones: `irq` fails to rise there, or rises somewhere else. A fault in the flag priority shows on `irq` only in the cycle after acknowledge, software write and overflow meet, so the bench drives those collisions deliberately. A fault in the synchronizer or edge detector shifts the event-mode increment away from the third edge, or doubles it, and can be seen within four cycles of a transition.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int unsigned DEF_WIDTH  = 16;
    localparam int unsigned SYNC_DEPTH = 2;

    typedef enum logic {
        SRC_CLK = 1'b0,
        SRC_EVT = 1'b1
    } src_e;

    typedef struct packed {
        logic wr;
        logic val;
    } flag_cmd_t;

    // Overflow beats software write, which beats acknowledge.
    function automatic logic flag_next(logic cur, logic ovf, flag_cmd_t cmd, logic ack);
        if (ovf)    return 1'b1;
        if (cmd.wr) return cmd.val;
        if (ack)    return 1'b0;
        return cur;
    endfunction

endpackage

// File: rtl/evt_sync.sv
module evt_sync
    import evt_timer_pkg::*;
#(
    parameter int unsigned DEPTH = SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic fall
);
    logic [DEPTH-1:0] chain;
    logic             last;

    generate
        for (genvar gi = 0; gi < DEPTH; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[gi] <= 1'b0;
                    else     chain[gi] <= chain[gi-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= chain[DEPTH-1];
    end

    assign fall = last & ~chain[DEPTH-1];

    // R8: a detected falling edge lasts exactly one cycle
    p_fall_single_r8: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);

endmodule

// File: rtl/count_core.sv
module count_core
    import evt_timer_pkg::*;
#(
    parameter int unsigned W = DEF_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_wr,
    input  logic         run_val,
    input  logic         tick,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         run,
    output logic         wrap
);
    localparam logic [W-1:0] ALL_ONES = '1;
    localparam logic [W-1:0] ONE      = W'(1);

    logic step;
    assign step = run & tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            run   <= 1'b0;
        end else begin
            if (run_wr) run <= run_val;
            if (step)
                count <= count + ONE;
            else if (!run && load_en)
                count <= load_val;
        end
    end

    assign wrap = step && (count == ALL_ONES);

    // R2: each active event advances the count by one
    p_inc_r2: assert property (@(posedge clk) disable iff (rst)
        (run && tick && count != ALL_ONES) |=> (count == $past(count) + ONE));
    // R3: a stopped timer with no load holds its count
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!run && !load_en) |=> $stable(count));
    // R4: wrap returns the count to zero
    p_wrap_zero_r4: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (count == '0));
    // R9: loads are taken when stopped and ignored while running
    p_load_r9: assert property (@(posedge clk) disable iff (rst)
        (!run && load_en) |=> (count == $past(load_val)));
    p_load_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (run && !tick && load_en) |=> $stable(count));

endmodule

// File: rtl/ovf_flag.sv
module ovf_flag
    import evt_timer_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ovf,
    input  flag_cmd_t cmd,
    input  logic      ack,
    output logic      irq
);
    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= flag_next(irq, ovf, cmd, ack);
    end

    // R4, R7: overflow sets the flag even against a write of 0
    p_set_r7: assert property (@(posedge clk) disable iff (rst)
        ovf |=> irq);
    // R5: the flag stays set with no clearing source
    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (irq && !ack && !cmd.wr) |=> irq);
    // R6: acknowledge clears the flag when nothing else acts
    p_ack_r6: assert property (@(posedge clk) disable iff (rst)
        (ack && !ovf && !cmd.wr) |=> !irq);

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int unsigned W = DEF_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_wr,
    input  logic         run_val,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_val,
    input  logic         flag_wr,
    input  logic         flag_val,
    input  logic         src_sel,
    input  logic         ext_evt,
    input  logic         irq_ack,
    output logic [W-1:0] count,
    output logic         running,
    output logic         irq
);
    src_e      src;
    logic      evt_fall;
    logic      tick;
    logic      wrap;
    flag_cmd_t fcmd;

    assign src  = src_e'(src_sel);
    assign fcmd = '{wr: flag_wr, val: flag_val};

    evt_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (ext_evt),
        .fall (evt_fall)
    );

    always_comb begin
        unique case (src)
            SRC_CLK: tick = 1'b1;
            SRC_EVT: tick = evt_fall;
            default: tick = 1'b0;
        endcase
    end

    count_core #(.W(W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .run_wr   (run_wr),
        .run_val  (run_val),
        .tick     (tick),
        .load_en  (cnt_wr),
        .load_val (cnt_val),
        .count    (count),
        .run      (running),
        .wrap     (wrap)
    );

    ovf_flag u_flag (
        .clk (clk),
        .rst (rst),
        .ovf (wrap),
        .cmd (fcmd),
        .ack (irq_ack),
        .irq (irq)
    );

    // R4: the flag rises only where the count has just come back to zero
    p_rise_at_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq) && !$past(flag_wr)) |-> (count == '0));

endmodule

// File: tb/tb_evt_timer.sv
`timescale 1ns/1ps
module tb_evt_timer;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         run_wr = 1'b0, run_val = 1'b0;
    logic         cnt_wr = 1'b0;
    logic [W-1:0] cnt_val = '0;
    logic         flag_wr = 1'b0, flag_val = 1'b0;
    logic         src_sel = 1'b0, ext_evt = 1'b1, irq_ack = 1'b0;
    logic [W-1:0] count;
    logic         running, irq;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         run;
        logic         irq;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    evt_timer #(.W(W)) dut (
        .clk(clk), .rst(rst), .run_wr(run_wr), .run_val(run_val),
        .cnt_wr(cnt_wr), .cnt_val(cnt_val), .flag_wr(flag_wr),
        .flag_val(flag_val), .src_sel(src_sel), .ext_evt(ext_evt),
        .irq_ack(irq_ack), .count(count), .running(running), .irq(irq)
    );

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_now(input logic [W-1:0] c, input logic r, input logic i, input string tag);
        exp_q.push_back('{cnt: c, run: r, irq: i});
        tag_q.push_back(tag);
    endtask

    task automatic set_run(input logic v);
        run_wr = 1'b1; run_val = v; cyc(1); run_wr = 1'b0;
    endtask

    task automatic load(input logic [W-1:0] v);
        cnt_wr = 1'b1; cnt_val = v; cyc(1); cnt_wr = 1'b0;
    endtask

    task automatic wr_flag(input logic v);
        flag_wr = 1'b1; flag_val = v; cyc(1); flag_wr = 1'b0;
    endtask

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (count !== e.cnt || running !== e.run || irq !== e.irq) begin
                fails++;
                $display("FAIL %s: actual count=%h run=%b irq=%b expected count=%h run=%b irq=%b",
                         t, count, running, irq, e.cnt, e.run, e.irq);
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        expect_now(16'h0000, 0, 0, "R1");                // R1 reset state

        load(16'h0005);
        expect_now(16'h0005, 0, 0, "R9");                // R9 load while stopped
        set_run(1'b1);
        expect_now(16'h0005, 1, 0, "R2");                // R2 start edge, no step yet
        cyc(4);
        expect_now(16'h0009, 1, 0, "R2");                // R2 four steps
        load(16'h0100);
        expect_now(16'h000A, 1, 0, "R9");                // R9 load ignored while running
        set_run(1'b0);
        cyc(5);
        expect_now(16'h000B, 0, 0, "R3");                // R3 frozen

        load(16'hFFFD);
        set_run(1'b1);
        cyc(2);
        expect_now(16'hFFFF, 1, 0, "R4");                // R4 before wrap
        cyc(1);
        expect_now(16'h0000, 1, 1, "R4");                // R4 wrap sets flag
        cyc(3);
        expect_now(16'h0003, 1, 1, "R5");                // R5 sticky
        set_run(1'b0);
        cyc(3);
        expect_now(16'h0004, 0, 1, "R5");                // R5 still set while stopped
        irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
        expect_now(16'h0004, 0, 0, "R6");                // R6 acknowledge clears

        wr_flag(1'b1);
        expect_now(16'h0004, 0, 1, "R7");                // R7 write 1
        wr_flag(1'b0);
        expect_now(16'h0004, 0, 0, "R7");                // R7 write 0

        load(16'hFFFF);
        set_run(1'b1);
        flag_wr = 1'b1; flag_val = 1'b0; irq_ack = 1'b1;
        cyc(1);
        flag_wr = 1'b0; irq_ack = 1'b0;
        expect_now(16'h0000, 1, 1, "R7");                // R7 overflow beats write 0 and ack
        set_run(1'b0);
        irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
        expect_now(16'h0001, 0, 0, "R6");                // R6 clear after collision

        src_sel = 1'b1;
        ext_evt = 1'b1;
        load(16'h0000);
        set_run(1'b1);
        cyc(5);
        expect_now(16'h0000, 1, 0, "R8");                // R8 steady high does not count
        ext_evt = 1'b0;
        cyc(2);
        expect_now(16'h0000, 1, 0, "R8");                // R8 not yet through the synchronizer
        cyc(1);
        expect_now(16'h0001, 1, 0, "R8");                // R8 third edge after the fall
        cyc(4);
        expect_now(16'h0001, 1, 0, "R8");                // R8 steady low does not count
        ext_evt = 1'b1;
        cyc(6);
        expect_now(16'h0001, 1, 0, "R8");                // R8 rising edge ignored
        for (int k = 0; k < 3; k++) begin
            ext_evt = 1'b0; cyc(4);
            ext_evt = 1'b1; cyc(4);
        end
        expect_now(16'h0004, 1, 0, "R8");                // R8 one step per falling edge

        cyc(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule